// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block carries out the data movement for one DMA channel after an arbiter has granted it. A one-cycle start pulse hands over a channel descriptor: source address, destination address and item size. The block then goes through a fixed series of phases. A startup phase comes first. A read data phase fetches one item from the source. A write data phase stores that item at the destination. A shutdown phase comes last. The block then returns to idle and reports completion with a one-cycle done pulse.

The bus side is a simple single-beat master port. A slave stretches either data phase by holding the ready input low. The only variable part of the cycle budget is the number of wait states. The service time of a request is four startup cycles, one cycle plus the read wait states, one cycle plus the write wait states, and three shutdown cycles. With no wait states that is nine cycles. A busy output is high in exactly those cycles, so counting busy cycles gives the per-request service time and the peak request rate.

Top module: `dma_xfer_seq`

## Requirements
- R1: While reset is asserted, and after reset until the first accepted start, busy, done, bus_rd and bus_wr are low, and bus_addr, bus_size and bus_wdata are zero.
- R2: A start pulse is accepted only while busy is low. A start that arrives while busy is high, including in the cycle where done is high, is ignored. The transfer in progress keeps the addresses, size and timing of the descriptor latched when it was accepted, and the descriptor inputs are not sampled again.
- R3: After an accepted start, busy is high for exactly 4 cycles before bus_rd first rises. bus_rd and bus_wr stay low in those cycles.
- R4: The read data phase asserts bus_rd with bus_addr equal to the latched source address. It lasts 1 cycle plus one cycle for each cycle that bus_ready is sampled low.
- R5: The value captured from bus_rdata is the one present in the read cycle where bus_ready is high. It keeps the low 8 bits when size is 0, the low 16 bits when size is 1, and the full word when size is 2 or 3. All other bits are cleared.
- R6: The write data phase begins in the cycle after the read completes. It asserts bus_wr with bus_addr equal to the latched destination address and bus_wdata equal to the captured value, unchanged across wait states. It lasts 1 cycle plus the number of cycles bus_ready is sampled low.
- R7: After the write completes there are exactly 3 shutdown cycles with busy high and no strobe. done is high only in the last of them, for a single cycle, and busy is low in the following cycle.
- R8: The busy cycles of one request total 9 plus the read wait states plus the write wait states; for example 13 for (1 read, 3 write) and 12 for (2 read, 1 write). A start in the first cycle after done begins a new request at once.
- R9: bus_size carries the latched size during both data phases. bus_addr and bus_size are zero outside the data phases, and bus_wdata is zero outside the write phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request from the channel arbiter |
| src_addr | input | ADDR_W | Source address of the item |
| dst_addr | input | ADDR_W | Destination address of the item |
| xfer_size | input | 2 | Item size: 0 byte, 1 halfword, 2/3 full word |
| bus_addr | output | ADDR_W | Bus address during data phases |
| bus_rd | output | 1 | Read strobe, high through the read data phase |
| bus_wr | output | 1 | Write strobe, high through the write data phase |
| bus_size | output | 2 | Item size during data phases |
| bus_wdata | output | DATA_W | Write data during the write phase |
| bus_rdata | input | DATA_W | Read data from the slave |
| bus_ready | input | 1 | Slave ready; low inserts a wait state |
| busy | output | 1 | High in every cycle spent servicing a request |
| done | output | 1 | One-cycle pulse in the last shutdown cycle |

## Verification
The embedded properties assume only that reset starts the block in idle. They accept any value on start, bus_ready and bus_rdata in every cycle. The stimulus uses that freedom: it pulses start in the middle of a transfer and in the done cycle, it toggles bus_ready at random outside the data phases, and it drives random data on bus_rdata during read wait states. The slave model in the bench holds ready low for a chosen number of cycles in each data phase, taken at random from zero to five, plus fixed cases with the wait-state pairs quoted in R8.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_READ  = 3'd2,
    PH_WRITE = 3'd3,
    PH_SHUT  = 3'd4
  } phase_t;

  // Service time of one request for the given wait-state counts.
  function automatic int service_cycles(input int startup_cyc, input int shut_cyc,
                                        input int rd_waits, input int wr_waits);
    return startup_cyc + (1 + rd_waits) + (1 + wr_waits) + shut_cyc;
  endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int STARTUP_CYC = 4,
  parameter int SHUT_CYC    = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   bus_ready,
  output phase_t phase,
  output logic   accept,
  output logic   rd_done,
  output logic   wr_done,
  output logic   busy,
  output logic   done
);
  localparam int MAX_CYC = (STARTUP_CYC > SHUT_CYC) ? STARTUP_CYC : SHUT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic             startup_last;
  logic             shut_last;

  assign startup_last = (phase == PH_START) && (cnt == CNT_W'(STARTUP_CYC - 1));
  assign shut_last    = (phase == PH_SHUT)  && (cnt == CNT_W'(SHUT_CYC - 1));
  assign accept       = (phase == PH_IDLE)  && start;
  assign rd_done      = (phase == PH_READ)  && bus_ready;
  assign wr_done      = (phase == PH_WRITE) && bus_ready;
  assign busy         = (phase != PH_IDLE);
  assign done         = shut_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (accept) phase <= PH_START;
          cnt <= '0;
        end
        PH_START: begin
          if (startup_last) begin
            phase <= PH_READ;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_READ: begin
          if (rd_done) phase <= PH_WRITE;
        end
        PH_WRITE: begin
          if (wr_done) begin
            phase <= PH_SHUT;
            cnt   <= '0;
          end
        end
        PH_SHUT: begin
          if (shut_last) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  // Independent length counters for the checks below.
  logic [CNT_W:0] chk_startup_len;
  logic [CNT_W:0] chk_shut_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_startup_len <= '0;
      chk_shut_len    <= '0;
    end else begin
      chk_startup_len <= (phase == PH_START) ? chk_startup_len + 1'b1 : '0;
      chk_shut_len    <= (phase == PH_SHUT)  ? chk_shut_len + 1'b1    : '0;
    end
  end

  a_r3_startup_len: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ && $past(phase) == PH_START) |-> chk_startup_len == (CNT_W+1)'(STARTUP_CYC));

  a_r7_shut_len: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && $past(phase) == PH_SHUT) |-> chk_shut_len == (CNT_W+1)'(SHUT_CYC));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  a_r2_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy);

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic              accept,
  input  logic              rd_done,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [1:0]        xfer_size,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata
);
  logic [ADDR_W-1:0] src_q;
  logic [ADDR_W-1:0] dst_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] hold_q;
  logic              in_data;

  // Keep the low (8 << size) bits of a word.
  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < (8 << sz));
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      size_q <= '0;
      hold_q <= '0;
    end else begin
      if (accept) begin
        src_q  <= src_addr;
        dst_q  <= dst_addr;
        size_q <= xfer_size;
      end
      if (rd_done) hold_q <= bus_rdata & size_mask(size_q);
    end
  end

  assign bus_rd    = (phase == PH_READ);
  assign bus_wr    = (phase == PH_WRITE);
  assign in_data   = bus_rd || bus_wr;
  assign bus_addr  = bus_rd ? src_q : (bus_wr ? dst_q : '0);
  assign bus_size  = in_data ? size_q : 2'b00;
  assign bus_wdata = bus_wr ? hold_q : '0;

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  a_r2_desc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> $stable(src_q) && $stable(dst_q) && $stable(size_q));

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int STARTUP_CYC = 4,
  parameter int SHUT_CYC    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [1:0]        xfer_size,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  output logic              busy,
  output logic              done
);
  phase_t phase;
  logic   accept;
  logic   rd_done;
  logic   wr_done;

  seq_ctrl #(
    .STARTUP_CYC(STARTUP_CYC),
    .SHUT_CYC   (SHUT_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bus_ready(bus_ready),
    .phase    (phase),
    .accept   (accept),
    .rd_done  (rd_done),
    .wr_done  (wr_done),
    .busy     (busy),
    .done     (done)
  );

  seq_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .accept   (accept),
    .rd_done  (rd_done),
    .src_addr (src_addr),
    .dst_addr (dst_addr),
    .xfer_size(xfer_size),
    .bus_rdata(bus_rdata),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_size (bus_size),
    .bus_wdata(bus_wdata)
  );

  a_r4_rd_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && $past(bus_rd)) |-> $stable(bus_addr));

  a_r6_wr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && $past(bus_wr)) |-> $stable(bus_addr) && $stable(bus_wdata));

  a_r6_wr_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_ready) |=> bus_wr);

  a_r7_shut_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_ready) |=> busy && !bus_rd && !bus_wr && !done);

  a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy && !bus_rd && !bus_wr);

  a_r1_wr_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> $past(bus_rd));

endmodule

// File: tb/dma_xfer_seq_test.sv
`timescale 1ns/1ps
module dma_xfer_seq_test;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] src_addr = '0;
  logic [AW-1:0] dst_addr = '0;
  logic [1:0]    xfer_size = '0;
  logic [AW-1:0] bus_addr;
  logic          bus_rd;
  logic          bus_wr;
  logic [1:0]    bus_size;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_ready = 1'b0;
  logic          busy;
  logic          done;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  dma_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
    .dst_addr(dst_addr), .xfer_size(xfer_size), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .busy(busy), .done(done)
  );

  function automatic int exp_len(input int rw, input int ww);
    return 4 + 1 + rw + 1 + ww + 3;
  endfunction

  function automatic logic [DW-1:0] exp_keep(input logic [DW-1:0] v, input logic [1:0] sz);
    if (sz == 2'd0) return v & 32'h0000_00FF;
    if (sz == 2'd1) return v & 32'h0000_FFFF;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Runs one request; called at a falling edge, returns at a falling edge
  // in the idle cycle after the request.
  task automatic xfer(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [1:0] sz,
                      input logic [DW-1:0] rv, input int rw, input int ww, input bit intrude);
    int len = exp_len(rw, ww);
    int rc = 0;
    int wc = 0;
    int busy_cnt = 0;
    logic [DW-1:0] ew = exp_keep(rv, sz);
    start = 1'b1; src_addr = s; dst_addr = d; xfer_size = sz;
    @(negedge clk);
    for (int k = 0; k <= len; k++) begin
      bit e_rd = (k >= 4) && (k < 5 + rw);
      bit e_wr = (k >= 5 + rw) && (k < 6 + rw + ww);
      bit e_busy = (k < len);
      if (busy) busy_cnt++;
      chk(busy == e_busy, "R3/R7 busy", 64'(busy), 64'(e_busy));
      chk(bus_rd == e_rd, "R3/R4 bus_rd", 64'(bus_rd), 64'(e_rd));
      chk(bus_wr == e_wr, "R6 bus_wr", 64'(bus_wr), 64'(e_wr));
      chk(done == (k == len - 1), "R7 done", 64'(done), 64'(k == len - 1));
      if (e_rd) chk(bus_addr == s, "R4 read addr", 64'(bus_addr), 64'(s));
      else if (e_wr) chk(bus_addr == d, "R6 write addr", 64'(bus_addr), 64'(d));
      else chk(bus_addr == '0, "R9 addr idle", 64'(bus_addr), 64'd0);
      chk(bus_size == ((e_rd || e_wr) ? sz : 2'd0), "R9 size", 64'(bus_size),
          64'((e_rd || e_wr) ? sz : 2'd0));
      chk(bus_wdata == (e_wr ? ew : '0), "R5/R6 wdata", 64'(bus_wdata), 64'(e_wr ? ew : '0));
      // Intruding requests in mid-transfer and in the done cycle.
      if (intrude && (k == 2 || k == len - 1)) begin
        start = 1'b1; src_addr = ~s; dst_addr = ~d; xfer_size = ~sz;
      end else begin
        start = 1'b0;
      end
      // Slave model.
      if (bus_rd) begin
        bus_ready = (rc == rw);
        bus_rdata = bus_ready ? rv : DW'($urandom);
        rc++;
      end else if (bus_wr) begin
        bus_ready = (wc == ww);
        bus_rdata = DW'($urandom);
        wc++;
      end else begin
        bus_ready = 1'($urandom_range(0, 1));
        bus_rdata = DW'($urandom);
      end
      @(negedge clk);
    end
    chk(busy_cnt == len, "R8 busy total", 64'(busy_cnt), 64'(len));
  endtask

  initial begin
    #(200000 * 4);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state, including a start pulse held during reset.
    start = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_rd && !bus_wr, "R1 strobes in reset", 64'({busy, done, bus_rd, bus_wr}), 64'd0);
    chk(bus_addr == '0 && bus_wdata == '0 && bus_size == '0, "R1 buses in reset",
        64'(bus_addr | bus_wdata), 64'd0);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", 64'({busy, done}), 64'd0);
    chk(bus_addr == '0 && !bus_rd && !bus_wr, "R1 bus idle after reset", 64'(bus_addr), 64'd0);

    // R8 directed budgets: 9, 13, 12 cycles.
    xfer(32'h1000_0000, 32'h2000_0000, 2'd2, 32'hCAFE_F00D, 0, 0, 1'b0);
    xfer(32'h1000_0004, 32'h2000_0004, 2'd2, 32'h1234_5678, 1, 3, 1'b0);
    xfer(32'h1000_0008, 32'h2000_0008, 2'd2, 32'h8765_4321, 2, 1, 1'b0);
    // R5 size masking.
    xfer(32'h3000_0001, 32'h4000_0001, 2'd0, 32'hA5A5_A5A5, 1, 0, 1'b0);
    xfer(32'h3000_0002, 32'h4000_0002, 2'd1, 32'hDEAD_BEEF, 0, 2, 1'b0);
    xfer(32'h3000_0003, 32'h4000_0003, 2'd3, 32'hFFFF_0001, 3, 3, 1'b0);
    // R2 intruding starts mid-transfer and in the done cycle.
    xfer(32'h5000_0000, 32'h6000_0000, 2'd1, 32'h0BAD_C0DE, 2, 2, 1'b1);
    xfer(32'h5000_0010, 32'h6000_0010, 2'd0, 32'h0000_0077, 0, 0, 1'b1);

    // Random mix, back to back.
    for (int i = 0; i < 80; i++) begin
      xfer(AW'($urandom), AW'($urandom), 2'($urandom_range(0, 3)), DW'($urandom),
           int'($urandom_range(0, 5)), int'($urandom_range(0, 5)), 1'($urandom_range(0, 1)));
    end

    start = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R2 idle at end", 64'({busy, done}), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule